// File: doc/BRIEF.md
# Event-Driven Trigger Channel Unit

This block sits on the receiving end of a timing network. It joins a set of isolated digital inputs and a set of trigger outputs to the event stream that the node exchanges with its central controller. A clean rising edge on any input becomes an event code, and that code is queued for the link transmitter. An event code arriving from the link is looked up in a table. The table entry names the outputs that should emit a pulse.

Each input goes through a two-flop synchroniser and then a qualifier. The qualifier only accepts a level that stays high for a programmed number of cycles; at 100 MHz, 50 cycles is 500 ns. Qualified edges are marked pending and granted into a 16-entry queue, lowest input index first, so edges that arrive together are all kept. Each input has its own code register. The mapping table holds one output mask per code, so one code can drive several outputs and several codes can share one output. Each output has a pulse timer whose width is counted in microseconds. A new hit during a pulse restarts the timer.

Top module: `trig_chan_unit`

## Requirements
- R1: An input produces exactly one event per high period when it has stayed high for at least QUAL_CYC (50) synchronised cycles. A high pulse shorter than that produces no event, and a level held high does not produce further events.
- R2: A config write with cfg_sel=0 sets the 8-bit code of input cfg_addr[2:0] from cfg_data[7:0]. After reset, the code of input i is i.
- R3: Edges that qualify in the same cycle on several inputs are each queued, in ascending input index order. None is lost while the queue holds at most 16 entries.
- R4: evt_out_valid is high whenever the queue is not empty. evt_out_code stays stable until a cycle with evt_out_ready high. Codes leave in the order they were queued.
- R5: A config write with cfg_sel=2 stores cfg_data[7:0] as the output mask of code cfg_addr, with bit i selecting output i. When rx_valid is sampled high with rx_code, every output whose mask bit is set rises on the second following clock edge.
- R6: A config write with cfg_sel=1 sets the width of output cfg_addr[2:0] from cfg_data[19:0], in units of US_CYC (100) cycles. The output stays high for exactly width*US_CYC cycles. A width of 0 acts as 1, and the width after reset is 1.
- R7: A hit on an output that is already pulsing restarts its timer, so the pulse ends width*US_CYC cycles after the restart.
- R8: Outputs whose mask bit is 0 for a received code are left unchanged. Several codes may select the same output.
- R9: During and right after reset, trig_out is all low and evt_out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_in | input | 8 | Isolated digital inputs, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 input code, 1 output width, 2 mapping table |
| cfg_addr | input | 8 | Channel index or event code of the write |
| cfg_data | input | 20 | Write data |
| rx_valid | input | 1 | Received event strobe from the link |
| rx_code | input | 8 | Received event code |
| evt_out_valid | output | 1 | Queue holds an event for the transmitter |
| evt_out_code | output | 8 | Event code at the queue head |
| evt_out_ready | input | 1 | Transmitter takes the head event |
| trig_out | output | 8 | Trigger pulse outputs |

## Verification
The assertions take for granted that the queue never overflows. That holds only if no more than 16 qualified edges wait unread. The stimulus queues at most 16 events while evt_out_ready is low, and it keeps the ready line high in every other phase. They also rely on configuration writes never hitting the same table entry that a received code reads in that cycle, and on inputs either staying low for at least one synchronised cycle between pulses or being held high deliberately. The random phases choose input subsets, masks and widths from a fixed seed, while the directed phases cover glitches, simultaneous edges on all inputs, retriggers and a zero width.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  typedef enum logic [1:0] {
    CFG_CODE  = 2'd0,
    CFG_WIDTH = 2'd1,
    CFG_MAP   = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/tcu_in_qual.sv
module tcu_in_qual #(
  parameter int QUAL_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit
);
  localparam int CW = $clog2(QUAL_CYC + 1);

  logic          s1_q, s2_q;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit_q, hit_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    hit_d  = 1'b0;
    if (!s2_q) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(QUAL_CYC - 1)) begin
        hit_d  = 1'b1;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      hit_q  <= hit_d;
    end
  end

  assign hit = hit_q;

  AST_QUAL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(s2_q) && !$past(done_q)); // R1
  AST_QUAL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |=> !hit_q); // R1
endmodule

// File: rtl/tcu_evt_arb.sv
module tcu_evt_arb #(
  parameter int NCH    = 8,
  parameter int CODE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCH-1:0]               hit,
  input  logic [NCH-1:0][CODE_W-1:0]   codes,
  input  logic                         full,
  output logic                         push,
  output logic [CODE_W-1:0]            push_code
);
  logic [NCH-1:0] pend_q, pend_d, grant;

  always_comb begin
    grant = full ? '0 : (pend_q & (~pend_q + NCH'(1)));
    pend_d = (pend_q & ~grant) | hit;
    push = |grant;
    push_code = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) push_code = push_code | codes[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~grant) != '0) |=> ((pend_q & $past(pend_q & ~grant)) == $past(pend_q & ~grant))); // R3
endmodule

// File: rtl/tcu_fifo.sv
module tcu_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop_req,
  output logic         full,
  output logic         nempty,
  output logic [W-1:0] rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          pop, wr_en;

  assign full   = (cnt_q == (AW+1)'(DEPTH));
  assign nempty = (cnt_q != '0);
  assign pop    = pop_req && nempty;
  assign wr_en  = push && !full;
  assign rdata  = mem[rd_q];

  always_comb begin
    wr_d  = wr_en ? wr_q + 1'b1 : wr_q;
    rd_d  = pop ? rd_q + 1'b1 : rd_q;
    cnt_d = cnt_q;
    if (wr_en && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!wr_en && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/tcu_pulse_timer.sv
module tcu_pulse_timer #(
  parameter int US_CYC  = 100,
  parameter int WIDTH_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [WIDTH_W-1:0] width,
  output logic               trig
);
  localparam int SW = $clog2(US_CYC + 1);

  logic               act_q, act_d;
  logic [WIDTH_W-1:0] left_q, left_d, w_eff;
  logic [SW-1:0]      sub_q, sub_d;

  assign w_eff = (width == '0) ? WIDTH_W'(1) : width;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    sub_d  = sub_q;
    if (fire) begin
      act_d  = 1'b1;
      left_d = w_eff - 1'b1;
      sub_d  = SW'(US_CYC - 1);
    end else if (act_q) begin
      if (sub_q == '0) begin
        if (left_q == '0) begin
          act_d = 1'b0;
        end else begin
          left_d = left_q - 1'b1;
          sub_d  = SW'(US_CYC - 1);
        end
      end else begin
        sub_d = sub_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
      sub_q  <= '0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
      sub_q  <= sub_d;
    end
  end

  assign trig = act_q;

  AST_FIRE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> trig); // R7
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !fire) |=> !trig); // R8

  if (US_CYC > 1) begin : g_min
    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig) |=> trig); // R6
  end
endmodule

// File: rtl/trig_chan_unit.sv
module trig_chan_unit
  import tcu_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int CODE_W   = 8,
  parameter int WIDTH_W  = 20,
  parameter int QUAL_CYC = 50,
  parameter int US_CYC   = 100,
  parameter int QDEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     chan_in,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [CODE_W-1:0]  cfg_addr,
  input  logic [WIDTH_W-1:0] cfg_data,
  input  logic               rx_valid,
  input  logic [CODE_W-1:0]  rx_code,
  output logic               evt_out_valid,
  output logic [CODE_W-1:0]  evt_out_code,
  input  logic               evt_out_ready,
  output logic [NCH-1:0]     trig_out
);
  localparam int CHI_W     = $clog2(NCH);
  localparam int MAP_DEPTH = 2 ** CODE_W;

  logic rst_s1_q, rst_s2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i = rst_s2_q;

  cfg_sel_e               sel;
  logic                   code_we, width_we, map_we;
  logic [CHI_W-1:0]       ch_idx;
  assign sel      = cfg_sel_e'(cfg_sel);
  assign code_we  = cfg_we && (sel == CFG_CODE);
  assign width_we = cfg_we && (sel == CFG_WIDTH);
  assign map_we   = cfg_we && (sel == CFG_MAP);
  assign ch_idx   = cfg_addr[CHI_W-1:0];

  logic [NCH-1:0][CODE_W-1:0]  code_q;
  logic [NCH-1:0][WIDTH_W-1:0] width_q;

  for (genvar g = 0; g < NCH; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) begin
        code_q[g]  <= CODE_W'(g);
        width_q[g] <= WIDTH_W'(1);
      end else begin
        if (code_we && (ch_idx == CHI_W'(g)))  code_q[g]  <= cfg_data[CODE_W-1:0];
        if (width_we && (ch_idx == CHI_W'(g))) width_q[g] <= cfg_data;
      end
    end
  end

  logic [NCH-1:0] hit;
  for (genvar g = 0; g < NCH; g++) begin : g_in
    tcu_in_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk(clk), .rst_n(rst_i), .din(chan_in[g]), .hit(hit[g]));
  end

  logic              q_full, q_push;
  logic [CODE_W-1:0] q_code;

  tcu_evt_arb #(.NCH(NCH), .CODE_W(CODE_W)) u_arb (
    .clk(clk), .rst_n(rst_i), .hit(hit), .codes(code_q), .full(q_full),
    .push(q_push), .push_code(q_code));

  tcu_fifo #(.DEPTH(QDEPTH), .W(CODE_W)) u_fifo (
    .clk(clk), .rst_n(rst_i), .push(q_push), .wdata(q_code),
    .pop_req(evt_out_ready), .full(q_full), .nempty(evt_out_valid),
    .rdata(evt_out_code));

  logic [NCH-1:0] map_mem [MAP_DEPTH];
  logic [NCH-1:0] rd_mask_q;
  logic           rd_vld_q;

  always_ff @(posedge clk) begin
    if (map_we)   map_mem[cfg_addr] <= cfg_data[NCH-1:0];
    if (rx_valid) rd_mask_q <= map_mem[rx_code];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rd_vld_q <= 1'b0;
    else        rd_vld_q <= rx_valid;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    tcu_pulse_timer #(.US_CYC(US_CYC), .WIDTH_W(WIDTH_W)) u_tmr (
      .clk(clk), .rst_n(rst_i), .fire(rd_vld_q && rd_mask_q[g]),
      .width(width_q[g]), .trig(trig_out[g]));
  end

  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    (evt_out_valid && !evt_out_ready) |=> (evt_out_valid && $stable(evt_out_code))); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i |-> (trig_out == '0) && !evt_out_valid); // R9
endmodule

// File: tb/trig_chan_unit_test.sv
module trig_chan_unit_test;
  localparam int US   = 100;
  localparam int NCH  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  chan_in;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_addr;
  logic [19:0] cfg_data;
  logic        rx_valid;
  logic [7:0]  rx_code;
  logic        evt_out_valid;
  logic [7:0]  evt_out_code;
  logic        evt_out_ready;
  logic [7:0]  trig_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0]  exp_code [NCH];
  logic [19:0] exp_width [NCH];
  logic [7:0]  exp_map [256];
  logic [7:0]  ev_log [64];
  int          nlog = 0;
  bit          logging = 0;

  always #4 clk = ~clk;

  trig_chan_unit uut (
    .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rx_valid(rx_valid), .rx_code(rx_code), .evt_out_valid(evt_out_valid),
    .evt_out_code(evt_out_code), .evt_out_ready(evt_out_ready),
    .trig_out(trig_out));

  always @(negedge clk) begin
    if (logging && evt_out_valid && evt_out_ready && nlog < 64) begin
      ev_log[nlog] = evt_out_code;
      nlog = nlog + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pulse_len(input logic [19:0] w);
    return ((w == 0) ? 1 : int'(w)) * US;
  endfunction

  task automatic cfg_write(input logic [1:0] s, input logic [7:0] a, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_code = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_inputs(input logic [7:0] m, input int hold);
    @(negedge clk);
    chan_in = m;
    repeat (hold) @(negedge clk);
    chan_in = 8'h00;
    repeat (20) @(negedge clk);
  endtask

  task automatic check_events(input logic [7:0] m, input string req);
    int n = 0;
    repeat (30) @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      if (m[i]) begin
        if (n < nlog) check(ev_log[n] == exp_code[i], req, ev_log[n], exp_code[i]);
        n++;
      end
    end
    check(nlog == n, req, nlog, n);
    nlog = 0;
  endtask

  task automatic fire_measure(input logic [7:0] c, input string req);
    int hi [NCH];
    logic [7:0] m;
    int maxw = 0;
    m = exp_map[c];
    for (int i = 0; i < NCH; i++) begin
      hi[i] = 0;
      if (m[i] && pulse_len(exp_width[i]) > maxw) maxw = pulse_len(exp_width[i]);
    end
    send_rx(c);
    check(trig_out == 8'h00, "R5 latency: low one edge after sample", trig_out, 0);
    @(negedge clk);
    check(trig_out == m, "R5 mask rises on second edge", trig_out, m);
    for (int i = 0; i < NCH; i++) if (trig_out[i]) hi[i]++;
    for (int n = 0; n < maxw + 10; n++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) if (trig_out[i]) hi[i]++;
    end
    for (int i = 0; i < NCH; i++)
      check(hi[i] == (m[i] ? pulse_len(exp_width[i]) : 0), req, hi[i],
            m[i] ? pulse_len(exp_width[i]) : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    int hi;
    logic [7:0] m;
    seed = $urandom(32'h5EED1234);
    rst_n = 1'b0; chan_in = 0; cfg_we = 0; cfg_sel = 0; cfg_addr = 0; cfg_data = 0;
    rx_valid = 0; rx_code = 0; evt_out_ready = 1'b1;
    repeat (5) @(negedge clk);
    check(trig_out == 0, "R9 trig low in reset", trig_out, 0);
    check(evt_out_valid == 0, "R9 valid low in reset", evt_out_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(trig_out == 0, "R9 trig low after reset", trig_out, 0);
    check(evt_out_valid == 0, "R9 valid low after reset", evt_out_valid, 0);
    logging = 1;
    for (int i = 0; i < NCH; i++) begin
      exp_code[i] = 8'(i);
      exp_width[i] = 20'd1;
    end

    // R2: reset codes equal input index
    pulse_inputs(8'h08, 80);
    check_events(8'h08, "R2 reset code");

    // R1: glitch shorter than qualification window
    pulse_inputs(8'hFF, 40);
    check_events(8'h00, "R1 short pulse ignored");

    // R1: held high gives one event
    pulse_inputs(8'h04, 600);
    check_events(8'h04, "R1 held high once");

    // R2: program codes
    for (int i = 0; i < NCH; i++) begin
      exp_code[i] = 8'($urandom);
      cfg_write(2'd0, 8'(i), {12'd0, exp_code[i]});
    end

    // R3: all inputs at once
    pulse_inputs(8'hFF, 80);
    check_events(8'hFF, "R3 simultaneous all");

    // R3/R1: random subsets
    for (int t = 0; t < 10; t++) begin
      m = 8'($urandom);
      pulse_inputs(m, 60 + ($urandom % 40));
      check_events(m, "R3 random subset order");
    end

    // R4: backpressure, 16 queued
    evt_out_ready = 1'b0;
    pulse_inputs(8'hFF, 80);
    pulse_inputs(8'hFF, 80);
    check(evt_out_valid == 1'b1, "R4 valid while queued", evt_out_valid, 1);
    check(evt_out_code == exp_code[0], "R4 head code", evt_out_code, exp_code[0]);
    repeat (20) @(negedge clk);
    check(evt_out_code == exp_code[0], "R4 head stable", evt_out_code, exp_code[0]);
    evt_out_ready = 1'b1;
    repeat (30) @(negedge clk);
    check(nlog == 16, "R3 sixteen kept", nlog, 16);
    for (int k = 0; k < 16; k++)
      check(ev_log[k] == exp_code[k % 8], "R4 drain order", ev_log[k], exp_code[k % 8]);
    check(evt_out_valid == 1'b0, "R4 valid low when empty", evt_out_valid, 0);
    nlog = 0;

    // R5/R6: mapping table and widths
    for (int c = 0; c < 256; c++) begin
      exp_map[c] = 8'($urandom);
      cfg_write(2'd2, 8'(c), {12'd0, exp_map[c]});
    end
    fire_measure(8'h10, "R6 reset width");
    for (int i = 0; i < NCH; i++) begin
      exp_width[i] = 20'(1 + ($urandom % 3));
      cfg_write(2'd1, 8'(i), exp_width[i]);
    end
    for (int t = 0; t < 8; t++) fire_measure(8'($urandom), "R6 pulse width");

    // R8: two codes share output 3, unmasked outputs untouched
    exp_map[8'hA1] = 8'h09; cfg_write(2'd2, 8'hA1, 20'h09);
    exp_map[8'hA2] = 8'h88; cfg_write(2'd2, 8'hA2, 20'h88);
    fire_measure(8'hA1, "R8 many to many A");
    fire_measure(8'hA2, "R8 many to many B");
    exp_map[8'hA3] = 8'h00; cfg_write(2'd2, 8'hA3, 20'h00);
    fire_measure(8'hA3, "R8 empty mask no pulse");

    // R6: width zero acts as one
    exp_width[5] = 20'd0; cfg_write(2'd1, 8'd5, 20'd0);
    exp_map[8'hB0] = 8'h20; cfg_write(2'd2, 8'hB0, 20'h20);
    fire_measure(8'hB0, "R6 width zero");

    // R7: retrigger restarts
    exp_width[0] = 20'd2; cfg_write(2'd1, 8'd0, 20'd2);
    exp_map[8'h55] = 8'h01; cfg_write(2'd2, 8'h55, 20'h01);
    send_rx(8'h55);
    repeat (149) @(negedge clk);
    check(trig_out[0] == 1'b1, "R7 active before retrigger", trig_out[0], 1);
    send_rx(8'h55);
    hi = 0;
    for (int n = 0; n < 260; n++) begin
      @(negedge clk);
      if (trig_out[0]) hi++;
    end
    check(hi == 2 * US, "R7 retrigger restarts", hi, 2 * US);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule